// File: doc/BRIEF.md
# Single-Line SPI Flash Command Engine

This block issues one half-duplex SPI command at a time on behalf of software that sees it only as a byte-addressed register window. Software first writes four things: a command byte, a count of bytes to send, a count of bytes to fetch, and a chip-select choice. It also fills a shared byte store with the bytes that follow the command. For a flash command these are the address bytes, most significant first at rising offsets, then any dummy bytes as 0xFF, then any write data. Software then sets the start bit. The engine pulls the chosen chip select low and clocks out the command byte and the send bytes on one data line. It then clocks in the fetch bytes and writes them into the same store, directly behind the bytes it sent. A busy bit stays high for the whole exchange.

The engine keeps a single internal store pointer. The pointer moves forward by one for every byte taken from or put into the store, keeps its value from one command to the next, and wraps at the end of the store. A pointer-reset bit returns it to the store base. The usual sequence is: reset the pointer, load the store, set the counts, start the command, poll busy, then read the fetched bytes at base + send count.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset, busy reads 0, all chip selects are high, SCK is low, and the command, count and select registers and every store byte read 0.
- R2: The command byte (0x45), send count (0x48), fetch count (0x4B) and select (0x1D, bits 1:0 only) read back as written. The start bit (0x47 bit 7) and the pointer-reset bit (0x02 bit 4) always read 0.
- R3: A command shifts the command byte, then the send-count bytes from the store in rising order, MSB first in SPI mode 0. MOSI changes only while SCK is low, and the bits are valid at each SCK rising edge.
- R4: Fetched bytes are sampled on SCK rising edges, MSB first, and stored at base + send count when the pointer started at 0. MOSI is held low while bytes are fetched.
- R5: A fetch count of 0 gives a write-only command with exactly (1 + send count) × 8 SCK pulses, and no store byte is changed.
- R6: Busy (0x4F bit 7, which is bit 31 of the status word at 0x4C) reads 1 from the cycle after the start write. The chip select rises 4 system clocks after the last SCK falling edge, and busy falls one clock after that.
- R7: While busy, a start write does not begin a second command, and writes to the command, count and select registers or to the store are ignored.
- R8: The store pointer advances once per byte moved, carries over between commands, returns to 0 on a pointer-reset write, and wraps from the last store byte (offset 69) to offset 0.
- R9: SCK runs at one quarter of the system clock: two clocks low, then two clocks high. SCK is low whenever no chip select is active.
- R10: Only the chip-select line picked by the select register goes low during a command. The other lines stay high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Byte write strobe for the register window |
| bus_addr | input | 8 | Byte offset into the register window |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | NUM_CS | Active-low chip selects |

## Verification
Two situations are hard to reach from the ports. The first is a write that arrives in the middle of a live command. The bench starts a command and then, while busy is still high, issues another start write, a command-register write and a store write. It then checks the SCK pulse count and the count of chip-select falls, and reads back the untouched register and store byte. The second is the pointer wrap at the far end of the store. The bench gets there by running a 68-byte send with no pointer reset and then a 3-byte send, which must emit offsets 68, 69 and 0.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

    // Byte offsets of the register window
    localparam logic [7:0] A_CTRL2 = 8'h02;  // control word, byte 2
    localparam logic [7:0] A_CSSEL = 8'h1D;
    localparam logic [7:0] A_OPC   = 8'h45;
    localparam logic [7:0] A_START = 8'h47;
    localparam logic [7:0] A_TXCNT = 8'h48;
    localparam logic [7:0] A_RXCNT = 8'h4B;
    localparam logic [7:0] A_STAT3 = 8'h4F;  // status word, byte 3
    localparam logic [7:0] A_FIFO  = 8'h80;

    localparam int CLR_BIT   = 4;
    localparam int START_BIT = 7;
    localparam int BUSY_BIT  = 7;

    localparam int SCK_DIV = 4;
    localparam int PH_W    = $clog2(SCK_DIV);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_TAIL,
        ST_FIN
    } seq_state_e;

    typedef struct packed {
        logic [7:0] opcode;
        logic [7:0] tx_cnt;
        logic [7:0] rx_cnt;
        logic [1:0] cs_sel;
    } cmd_t;

    function automatic logic in_store(logic [7:0] a, int depth);
        return (int'(a) >= int'(A_FIFO)) && (int'(a) < int'(A_FIFO) + depth);
    endfunction

endpackage

// File: rtl/spi_cmd_regs.sv
module spi_cmd_regs
    import spi_cmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_wr,
    input  logic [7:0] bus_addr,
    input  logic [7:0] bus_wdata,
    input  logic       busy,
    output cmd_t       cmd,
    output logic       start,
    output logic       ptr_clr,
    output logic [7:0] reg_rdata
);

    logic wr_ok;
    assign wr_ok = bus_wr && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd <= '0;
        end else if (wr_ok) begin
            case (bus_addr)
                A_OPC:   cmd.opcode <= bus_wdata;
                A_TXCNT: cmd.tx_cnt <= bus_wdata;
                A_RXCNT: cmd.rx_cnt <= bus_wdata;
                A_CSSEL: cmd.cs_sel <= bus_wdata[1:0];
                default: ;
            endcase
        end
    end

    assign start   = wr_ok && (bus_addr == A_START) && bus_wdata[START_BIT];
    assign ptr_clr = wr_ok && (bus_addr == A_CTRL2) && bus_wdata[CLR_BIT];

    always_comb begin
        case (bus_addr)
            A_OPC:   reg_rdata = cmd.opcode;
            A_TXCNT: reg_rdata = cmd.tx_cnt;
            A_RXCNT: reg_rdata = cmd.rx_cnt;
            A_CSSEL: reg_rdata = {6'b0, cmd.cs_sel};
            A_STAT3: reg_rdata = {busy, 7'b0};
            default: reg_rdata = 8'h00;
        endcase
    end

    // R7: command registers hold still while a transaction runs
    a_r7_cmd_frozen: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(cmd));

endmodule

// File: rtl/spi_cmd_store.sv
module spi_cmd_store #(
    parameter int DEPTH = 70,
    parameter int PW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_we,
    input  logic [PW-1:0] bus_idx,
    input  logic [7:0]    bus_wd,
    output logic [7:0]    bus_rd,
    input  logic          eng_we,
    input  logic [PW-1:0] eng_idx,
    input  logic [7:0]    eng_wd,
    output logic [7:0]    eng_rd
);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
        end else begin
            if (bus_we) mem[bus_idx] <= bus_wd;
            if (eng_we) mem[eng_idx] <= eng_wd;
        end
    end

    assign bus_rd = mem[bus_idx];
    assign eng_rd = mem[eng_idx];

    // R7: bus and engine never write the store in the same cycle
    a_r7_single_writer: assert property (@(posedge clk) disable iff (rst)
        !(bus_we && eng_we));

endmodule

// File: rtl/spi_cmd_seq.sv
module spi_cmd_seq
    import spi_cmd_pkg::*;
#(
    parameter int DEPTH  = 70,
    parameter int PW     = $clog2(DEPTH),
    parameter int NUM_CS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              ptr_clr,
    input  cmd_t              cmd,
    input  logic              miso,
    input  logic [7:0]        store_rd,
    output logic [PW-1:0]     ptr,
    output logic              store_we,
    output logic [7:0]        store_wd,
    output logic              busy,
    output logic              sck,
    output logic              mosi,
    output logic [NUM_CS-1:0] cs_n
);

    seq_state_e      state;
    logic [PH_W-1:0] phase;
    logic [PH_W-1:0] tail_cnt;
    logic [2:0]      bit_cnt;
    logic [7:0]      tx_left;
    logic [7:0]      rx_left;
    logic            in_rx;
    logic [7:0]      sh_out;
    logic [7:0]      sh_in;
    logic [1:0]      cs_lat;
    logic            byte_end;
    logic            cs_on;
    logic [PW-1:0]   ptr_nxt;

    assign byte_end = (state == ST_SHIFT) && (phase == PH_W'(SCK_DIV - 1)) && (bit_cnt == 3'd0);
    assign ptr_nxt  = (ptr == PW'(DEPTH - 1)) ? '0 : ptr + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            phase    <= '0;
            tail_cnt <= '0;
            bit_cnt  <= '0;
            tx_left  <= '0;
            rx_left  <= '0;
            in_rx    <= 1'b0;
            sh_out   <= '0;
            sh_in    <= '0;
            cs_lat   <= '0;
            ptr      <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (ptr_clr) ptr <= '0;
                    if (start) begin
                        state   <= ST_SHIFT;
                        sh_out  <= cmd.opcode;
                        tx_left <= cmd.tx_cnt;
                        rx_left <= cmd.rx_cnt;
                        cs_lat  <= cmd.cs_sel;
                        in_rx   <= 1'b0;
                        phase   <= '0;
                        bit_cnt <= 3'd7;
                    end
                end
                ST_SHIFT: begin
                    phase <= phase + 1'b1;
                    if (phase == PH_W'(SCK_DIV / 2 - 1)) sh_in <= {sh_in[6:0], miso};
                    if (phase == PH_W'(SCK_DIV - 1)) begin
                        if (bit_cnt != 3'd0) begin
                            sh_out  <= {sh_out[6:0], 1'b0};
                            bit_cnt <= bit_cnt - 1'b1;
                        end else begin
                            bit_cnt <= 3'd7;
                            if (in_rx || (tx_left != 8'd0)) ptr <= ptr_nxt;
                            if (tx_left != 8'd0) begin
                                sh_out  <= store_rd;
                                tx_left <= tx_left - 1'b1;
                                in_rx   <= 1'b0;
                            end else if (rx_left != 8'd0) begin
                                sh_out  <= 8'h00;
                                rx_left <= rx_left - 1'b1;
                                in_rx   <= 1'b1;
                            end else begin
                                state    <= ST_TAIL;
                                tail_cnt <= '0;
                                in_rx    <= 1'b0;
                            end
                        end
                    end
                end
                ST_TAIL: begin
                    tail_cnt <= tail_cnt + 1'b1;
                    if (tail_cnt == PH_W'(SCK_DIV - 1)) state <= ST_FIN;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign store_we = byte_end && in_rx;
    assign store_wd = sh_in;
    assign busy     = (state != ST_IDLE);
    assign sck      = (state == ST_SHIFT) && phase[PH_W-1];
    assign mosi     = (state == ST_SHIFT) && sh_out[7];
    assign cs_on    = (state == ST_SHIFT) || (state == ST_TAIL);

    for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
        assign cs_n[g] = !(cs_on && (int'(cs_lat) == g));
    end

    // R10: at most one chip select active
    a_r10_cs_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~cs_n));

    // R9: clock only toggles inside a selected window
    a_r9_sck_needs_cs: assert property (@(posedge clk) disable iff (rst)
        sck |-> !(&cs_n));

    // R9: two clocks low before each rising edge, two high before each fall
    a_r9_sck_low_half: assert property (@(posedge clk) disable iff (rst)
        $rose(sck) |-> !$past(sck, 2));
    a_r9_sck_high_half: assert property (@(posedge clk) disable iff (rst)
        $fell(sck) |-> $past(sck, 2));

    // R6: busy covers the select window and the cycle after release
    a_r6_busy_covers_cs: assert property (@(posedge clk) disable iff (rst)
        !(&cs_n) |-> busy);
    a_r6_busy_after_release: assert property (@(posedge clk) disable iff (rst)
        $rose(&cs_n) |-> busy);

    // R8: pointer stays inside the store
    a_r8_ptr_range: assert property (@(posedge clk) disable iff (rst)
        int'(ptr) < DEPTH);

endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
    import spi_cmd_pkg::*;
#(
    parameter int FIFO_DEPTH = 70,
    parameter int NUM_CS     = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [7:0]        bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              spi_sck,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic [NUM_CS-1:0] spi_cs_n
);

    localparam int PW = $clog2(FIFO_DEPTH);

    cmd_t          cmd;
    logic          start;
    logic          ptr_clr;
    logic          busy;
    logic [7:0]    reg_rdata;
    logic          hit;
    logic [PW-1:0] bus_idx;
    logic [7:0]    bus_store_rd;
    logic [PW-1:0] eng_ptr;
    logic          eng_we;
    logic [7:0]    eng_wd;
    logic [7:0]    eng_rd;

    assign hit     = in_store(bus_addr, FIFO_DEPTH);
    assign bus_idx = PW'(bus_addr - A_FIFO);

    spi_cmd_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .busy      (busy),
        .cmd       (cmd),
        .start     (start),
        .ptr_clr   (ptr_clr),
        .reg_rdata (reg_rdata)
    );

    spi_cmd_store #(.DEPTH(FIFO_DEPTH), .PW(PW)) u_store (
        .clk     (clk),
        .rst     (rst),
        .bus_we  (bus_wr && hit && !busy),
        .bus_idx (bus_idx),
        .bus_wd  (bus_wdata),
        .bus_rd  (bus_store_rd),
        .eng_we  (eng_we),
        .eng_idx (eng_ptr),
        .eng_wd  (eng_wd),
        .eng_rd  (eng_rd)
    );

    spi_cmd_seq #(.DEPTH(FIFO_DEPTH), .PW(PW), .NUM_CS(NUM_CS)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .ptr_clr  (ptr_clr),
        .cmd      (cmd),
        .miso     (spi_miso),
        .store_rd (eng_rd),
        .ptr      (eng_ptr),
        .store_we (eng_we),
        .store_wd (eng_wd),
        .busy     (busy),
        .sck      (spi_sck),
        .mosi     (spi_mosi),
        .cs_n     (spi_cs_n)
    );

    assign bus_rdata = hit ? bus_store_rd : reg_rdata;

endmodule

// File: tb/sim_spi_cmd_engine.sv
module sim_spi_cmd_engine;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       spi_sck;
    logic       spi_mosi;
    logic       spi_miso = 1'b0;
    logic [3:0] spi_cs_n;

    spi_cmd_engine u0 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sck(spi_sck),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // Monitor / slave state
    logic [7:0] mon_b [80];
    logic [7:0] rx_pat [16];
    logic [7:0] fm [70];
    logic [7:0] cur = 8'h00;
    int rises, cs_falls, fall_idx, last_fall, cs_rise, busy_fall, rise_a, rise_b;
    int exp_tx;
    logic [3:0] low_mask;
    logic prev_sck = 1'b0, prev_any = 1'b0, prev_busy = 1'b0;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic slave_bit(int g);
        int b = g / 8 - (1 + exp_tx);
        if (b < 0 || b >= 16) return 1'b0;
        return rx_pat[b][7 - (g % 8)];
    endfunction

    task automatic mon_clear();
        rises = 0; cs_falls = 0; fall_idx = 0; last_fall = 0; cs_rise = 0;
        busy_fall = 0; rise_a = 0; rise_b = 0; low_mask = 4'h0;
        for (int i = 0; i < 80; i++) mon_b[i] = 8'hxx;
    endtask

    always @(negedge clk) begin
        logic any_low;
        #2;
        any_low = ~&spi_cs_n;
        if (any_low && !prev_any) begin
            cs_falls++;
            fall_idx = 0;
            spi_miso = slave_bit(0);
        end
        if (!any_low && prev_any) cs_rise = cyc;
        low_mask = low_mask | ~spi_cs_n;
        if (spi_sck && !prev_sck) begin
            rises++;
            if (rises == 1) rise_a = cyc;
            if (rises == 2) rise_b = cyc;
            cur = {cur[6:0], spi_mosi};
            if (rises % 8 == 0 && rises / 8 <= 80) mon_b[rises / 8 - 1] = cur;
        end
        if (!spi_sck && prev_sck) begin
            last_fall = cyc;
            fall_idx++;
            spi_miso = slave_bit(fall_idx);
        end
        if (bus_addr == 8'h4F) begin
            if (prev_busy && !bus_rdata[7]) busy_fall = cyc;
            prev_busy = bus_rdata[7];
        end
        prev_sck = spi_sck;
        prev_any = any_low;
    end

    task automatic bwr(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic brd(logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic load_store(int idx, logic [7:0] d);
        fm[idx] = d;
        bwr(8'h80 + 8'(idx), d);
    endtask

    task automatic start_cmd(logic [7:0] opc, int tx, int rx, logic [1:0] sel);
        bwr(8'h45, opc);
        bwr(8'h48, 8'(tx));
        bwr(8'h4B, 8'(rx));
        bwr(8'h1D, {6'b0, sel});
        mon_clear();
        exp_tx = tx;
        bwr(8'h47, 8'h80);
        bus_addr = 8'h4F;
        prev_busy = 1'b1;
        #1 check("R6 busy after start", 32'(bus_rdata[7]), 32'd1);
    endtask

    task automatic wait_done();
        bus_addr = 8'h4F;
        do begin
            @(negedge clk);
            #1;
        end while (bus_rdata[7]);
        @(negedge clk);
    endtask

    task automatic run_cmd(logic [7:0] opc, int tx, int rx, logic [1:0] sel);
        start_cmd(opc, tx, rx, sel);
        wait_done();
    endtask

    task automatic t_reset();
        logic [7:0] d;
        brd(8'h4F, d); check("R1 busy", 32'(d), 32'h0);
        brd(8'h45, d); check("R1 opcode", 32'(d), 32'h0);
        brd(8'h1D, d); check("R1 select", 32'(d), 32'h0);
        brd(8'h80, d); check("R1 store", 32'(d), 32'h0);
        check("R1 cs_n", 32'(spi_cs_n), 32'hF);
        check("R1 sck", 32'(spi_sck), 32'h0);
    endtask

    task automatic t_regs();
        logic [7:0] d;
        bwr(8'h45, 8'hA5); brd(8'h45, d); check("R2 opcode", 32'(d), 32'hA5);
        bwr(8'h48, 8'h3C); brd(8'h48, d); check("R2 tx count", 32'(d), 32'h3C);
        bwr(8'h4B, 8'h07); brd(8'h4B, d); check("R2 rx count", 32'(d), 32'h07);
        bwr(8'h1D, 8'hFE); brd(8'h1D, d); check("R2 select low bits", 32'(d), 32'h02);
        bwr(8'h02, 8'h10); brd(8'h02, d); check("R2 clear reads 0", 32'(d), 32'h0);
    endtask

    task automatic t_write_only();
        logic [7:0] d;
        bwr(8'h02, 8'h10);
        load_store(0, 8'h12); load_store(1, 8'h34); load_store(2, 8'h56);
        load_store(3, 8'h9C); load_store(4, 8'h77);
        run_cmd(8'h02, 4, 0, 2'd2);
        check("R3 opcode byte", 32'(mon_b[0]), 32'h02);
        for (int k = 0; k < 4; k++) check("R3 tx byte", 32'(mon_b[k + 1]), 32'(fm[k]));
        check("R5 pulse count", 32'(rises), 32'd40);
        check("R10 only cs2", 32'(low_mask), 32'h4);
        check("R6 cs release gap", 32'(cs_rise - last_fall), 32'd4);
        check("R6 busy fall gap", 32'(busy_fall - last_fall), 32'd5);
        check("R9 sck period", 32'(rise_b - rise_a), 32'd4);
        brd(8'h84, d); check("R5 store untouched", 32'(d), 32'h77);
        brd(8'h47, d); check("R2 start reads 0", 32'(d), 32'h0);
    endtask

    task automatic t_read();
        logic [7:0] d;
        bwr(8'h02, 8'h10);
        load_store(0, 8'h01); load_store(1, 8'h23); load_store(2, 8'h45);
        load_store(3, 8'hFF);
        rx_pat[0] = 8'hC3; rx_pat[1] = 8'h5A; rx_pat[2] = 8'h81;
        run_cmd(8'h0B, 4, 3, 2'd1);
        check("R3 read opcode", 32'(mon_b[0]), 32'h0B);
        check("R3 dummy byte", 32'(mon_b[4]), 32'hFF);
        check("R4 pulse count", 32'(rises), 32'd64);
        for (int k = 0; k < 3; k++) check("R4 mosi low in fetch", 32'(mon_b[5 + k]), 32'h00);
        for (int k = 0; k < 3; k++) begin
            brd(8'h84 + 8'(k), d);
            check("R4 fetched byte", 32'(d), 32'(rx_pat[k]));
        end
        brd(8'h83, d); check("R4 dummy kept", 32'(d), 32'hFF);
        check("R10 only cs1", 32'(low_mask), 32'h2);
    endtask

    task automatic t_busy_writes();
        logic [7:0] d;
        bwr(8'h02, 8'h10);
        load_store(0, 8'hAA); load_store(1, 8'hBB);
        start_cmd(8'h9F, 2, 0, 2'd0);
        bwr(8'h47, 8'h80);
        bwr(8'h45, 8'h00);
        bwr(8'h80, 8'h11);
        bwr(8'h1D, 8'h03);
        wait_done();
        repeat (20) @(negedge clk);
        check("R7 no second command", 32'(cs_falls), 32'd1);
        check("R7 pulse count", 32'(rises), 32'd24);
        brd(8'h45, d); check("R7 opcode kept", 32'(d), 32'h9F);
        brd(8'h80, d); check("R7 store kept", 32'(d), 32'hAA);
        brd(8'h1D, d); check("R7 select kept", 32'(d), 32'h00);
        check("R10 only cs0", 32'(low_mask), 32'h1);
    endtask

    task automatic t_pointer();
        bwr(8'h02, 8'h10);
        load_store(0, 8'hA1); load_store(1, 8'hB2); load_store(2, 8'hC3); load_store(3, 8'hD4);
        run_cmd(8'h11, 2, 0, 2'd0);
        check("R8 first pair a", 32'(mon_b[1]), 32'hA1);
        check("R8 first pair b", 32'(mon_b[2]), 32'hB2);
        run_cmd(8'h11, 2, 0, 2'd0);
        check("R8 carried a", 32'(mon_b[1]), 32'hC3);
        check("R8 carried b", 32'(mon_b[2]), 32'hD4);
        bwr(8'h02, 8'h10);
        run_cmd(8'h11, 1, 0, 2'd0);
        check("R8 after clear", 32'(mon_b[1]), 32'hA1);
    endtask

    task automatic t_wrap();
        bwr(8'h02, 8'h10);
        for (int i = 0; i < 70; i++) load_store(i, 8'(i) ^ 8'h5A);
        run_cmd(8'h22, 68, 0, 2'd3);
        check("R5 long pulse count", 32'(rises), 32'd552);
        run_cmd(8'h22, 3, 0, 2'd3);
        check("R8 wrap 68", 32'(mon_b[1]), 32'(fm[68]));
        check("R8 wrap 69", 32'(mon_b[2]), 32'(fm[69]));
        check("R8 wrap to 0", 32'(mon_b[3]), 32'(fm[0]));
        check("R10 only cs3", 32'(low_mask), 32'h8);
    endtask

    initial begin
        mon_clear();
        exp_tx = 0;
        for (int i = 0; i < 16; i++) rx_pat[i] = 8'h00;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_regs();
        t_write_only();
        t_read();
        t_busy_writes();
        t_pointer();
        t_wrap();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog act=running exp=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule